// File: doc/BRIEF.md
# Wide Shift and Rotate Unit

This block is the shift and rotate execution unit of a stack machine with 256-bit words. For each accepted operation it takes an opcode byte and two full-width operands. The first operand popped from the stack gives the bit count. The second operand popped is the word that is moved. The unit registers a 256-bit result and a valid flag on the next clock edge.

Five operations are supported: left shift, logical right shift, arithmetic right shift, left rotate and right rotate. The bit count is a full-width unsigned value. For the three shifts, any count of 256 or more saturates to a defined result. For the two rotates, only the count modulo 256 has an effect. An opcode byte outside the five assigned codes produces a zero result, with an illegal-opcode flag raised beside the valid flag.

Top module: `wide_shift_unit`

## Requirements
- R1: Opcode byte 0x1b selects left shift, 0x1c selects logical right shift, 0x1d selects arithmetic right shift, 0x1e selects left rotate and 0x1f selects right rotate. Any other opcode value returns a result of zero with illegal_op at 1. For the five assigned codes, illegal_op is 0.
- R2: Left shift returns (data * 2^amount) mod 2^256.
- R3: For left shift and for logical right shift, any amount of 256 or more returns all zeros.
- R4: Logical right shift of data by an amount below 256 fills the vacated high bits with zeros.
- R5: Arithmetic right shift treats the amount as unsigned. For an amount below 256 it fills the vacated high bits with copies of data bit 255.
- R6: Arithmetic right shift by 256 or more returns all zeros when data bit 255 is 0, and all ones when data bit 255 is 1.
- R7: Left rotate moves data left by amount mod 256 bits. Bits that leave at bit 255 re-enter at bit 0. Amount bits 255 down to 8 have no effect on the result.
- R8: Right rotate moves data right by amount mod 256 bits. Bits that leave at bit 0 re-enter at bit 255. Amount bits 255 down to 8 have no effect on the result.
- R9: When in_valid is 1 at a rising edge, result, illegal_op and out_valid=1 appear after that edge. When in_valid is 0 at a rising edge, out_valid goes to 0 and result holds its value.
- R10: A synchronous reset clears out_valid, illegal_op and result to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| opcode | input | 8 | Operation code byte |
| amount | input | 256 | Bit count (first popped operand), unsigned |
| data | input | 256 | Word to shift or rotate (second popped operand) |
| out_valid | output | 1 | Registered result is valid |
| result | output | 256 | Registered result word |
| illegal_op | output | 1 | Registered flag for an unassigned opcode |

## Verification
The bench builds the unit with its default width of 256 bits. This puts the saturation boundary at exactly 256. It also makes the full 248-bit upper field of the amount available to saturate shifts, or to be ignored by rotates. The directed vectors cover amounts 0, 1, 255, 256 and a lone bit 255. They also cover rotate amounts with the upper bits set, and sign-fill data with bit 255 both clear and set. Random operands then drive every barrel stage in every mode. Each result is checked against a behavioural model built on the language's own shift operators.

// File: rtl/wide_shift_unit.sv
module wide_shift_unit #(
  parameter int DW = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] amount,
  input  logic [DW-1:0] data,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          illegal_op
);
  localparam int LW = $clog2(DW);
  localparam logic [7:0] OP_SHL = 8'h1b;
  localparam logic [7:0] OP_SHR = 8'h1c;
  localparam logic [7:0] OP_SAR = 8'h1d;
  localparam logic [7:0] OP_ROL = 8'h1e;
  localparam logic [7:0] OP_ROR = 8'h1f;

  logic          sat;
  logic [LW-1:0] sh, rot_sh;
  logic          fill;
  logic [DW-1:0] ls [0:LW];
  logic [DW-1:0] rs [0:LW];
  logic [DW-1:0] rt [0:LW];
  logic [DW-1:0] nxt;
  logic          bad;

  assign sat    = |amount[DW-1:LW];
  assign sh     = amount[LW-1:0];
  assign rot_sh = (opcode == OP_ROR) ? (~sh + 1'b1) : sh;
  assign fill   = (opcode == OP_SAR) & data[DW-1];

  assign ls[0] = data;
  assign rs[0] = data;
  assign rt[0] = data;

  for (genvar i = 0; i < LW; i++) begin : g_stage
    localparam int S = 1 << i;
    assign ls[i+1] = sh[i]     ? {ls[i][DW-1-S:0], {S{1'b0}}}        : ls[i];
    assign rs[i+1] = sh[i]     ? {{S{fill}}, rs[i][DW-1:S]}          : rs[i];
    assign rt[i+1] = rot_sh[i] ? {rt[i][DW-1-S:0], rt[i][DW-1:DW-S]} : rt[i];
  end

  always_comb begin
    bad = 1'b0;
    unique case (opcode)
      OP_SHL:          nxt = sat ? '0 : ls[LW];
      OP_SHR:          nxt = sat ? '0 : rs[LW];
      OP_SAR:          nxt = sat ? {DW{data[DW-1]}} : rs[LW];
      OP_ROL, OP_ROR:  nxt = rt[LW];
      default: begin
        nxt = '0;
        bad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      illegal_op <= 1'b0;
      result     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= nxt;
        illegal_op <= bad;
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_result_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  a_r1_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal_op) |-> (result == '0));
  a_r3_shl_saturates: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_SHL && amount >= DW) |=> (result == '0));
  a_r6_sar_saturates: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_SAR && amount >= DW) |=> (result == {DW{$past(data[DW-1])}}));
  a_r7_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode == OP_ROL || opcode == OP_ROR)) |=>
      ($countones(result) == $countones($past(data))));
  a_r10_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !illegal_op));
endmodule

// File: tb/wide_shift_unit_tb.sv
`timescale 1ns/1ps
module wide_shift_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   opcode = 8'h00;
  logic [255:0] amount = '0;
  logic [255:0] data = '0;
  logic         out_valid;
  logic [255:0] result;
  logic         illegal_op;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic         exp_v = 1'b0;
  logic [255:0] exp_r = '0;
  logic         exp_i = 1'b0;

  always #2.5 clk = ~clk;

  wide_shift_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .amount(amount), .data(data), .out_valid(out_valid),
    .result(result), .illegal_op(illegal_op)
  );

  function automatic logic [255:0] model(input logic [7:0] op, input logic [255:0] a,
                                          input logic [255:0] d, output logic ill);
    logic big;
    int k;
    big = (a > 256'd255);
    k = int'(a[7:0]);
    ill = 1'b0;
    case (op)
      8'h1b: return big ? '0 : (d << k);
      8'h1c: return big ? '0 : (d >> k);
      8'h1d: return big ? {256{d[255]}} : 256'($unsigned($signed(d) >>> k));
      8'h1e: return (d << k) | (d >> (256 - k));
      8'h1f: return (d >> k) | (d << (256 - k));
      default: begin ill = 1'b1; return '0; end
    endcase
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (out_valid !== exp_v || result !== exp_r || (exp_v && illegal_op !== exp_i)) begin
      errors++;
      $display("FAIL %s: got v=%b ill=%b r=%h exp v=%b ill=%b r=%h",
               tag, out_valid, illegal_op, result, exp_v, exp_i, exp_r);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] op, input logic [255:0] a,
                      input logic [255:0] d, input string tag);
    logic ill;
    in_valid = v; opcode = op; amount = a; data = d;
    @(posedge clk);
    if (rst) begin
      exp_v = 1'b0; exp_r = '0; exp_i = 1'b0;
    end else begin
      exp_v = v;
      if (v) begin
        exp_r = model(op, a, d, ill);
        exp_i = ill;
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  localparam logic [255:0] NEG = {4'h9, 252'h123456789abcdef0fedcba9876543210f0f0};
  localparam logic [255:0] POS = {4'h5, 252'h0badc0ffee0ddf00d5eed5eed5ee1234abcd};
  localparam logic [255:0] HIB = {1'b1, 255'd0};

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || illegal_op !== 1'b0) begin
      errors++;
      $display("FAIL R10: got v=%b ill=%b exp v=0 ill=0", out_valid, illegal_op);
    end
    rst = 1'b0;

    step(1, 8'h1b, 256'd0,   POS, "R2 shl by 0");
    step(1, 8'h1b, 256'd1,   POS, "R2 shl by 1");
    step(1, 8'h1b, 256'd255, 256'd1, "R2 shl by 255");
    step(1, 8'h1b, 256'd256, POS, "R3 shl by 256");
    step(1, 8'h1b, HIB,      POS, "R3 shl by 2^255");
    step(1, 8'h1c, 256'd256, NEG, "R3 shr by 256");
    step(1, 8'h1c, {1'b1, 247'd0, 8'd3}, NEG, "R3 shr upper bits");
    step(1, 8'h1c, 256'd4,   NEG, "R4 shr zero fill");
    step(1, 8'h1c, 256'd255, NEG, "R4 shr by 255");
    step(1, 8'h1d, 256'd4,   NEG, "R5 sar negative");
    step(1, 8'h1d, 256'd4,   POS, "R5 sar positive");
    step(1, 8'h1d, 256'd255, NEG, "R5 sar by 255");
    step(1, 8'h1d, 256'd256, NEG, "R6 sar sat negative");
    step(1, 8'h1d, HIB,      POS, "R6 sar sat positive");
    step(1, 8'h1e, 256'd1,   HIB, "R7 rol wrap");
    step(1, 8'h1e, {8'hff, 240'd0, 8'd5}, NEG, "R7 rol upper ignored");
    step(1, 8'h1e, 256'd256, NEG, "R7 rol by 256");
    step(1, 8'h1f, 256'd1,   256'd1, "R8 ror wrap");
    step(1, 8'h1f, {8'h80, 240'd7, 8'd77}, POS, "R8 ror upper ignored");
    step(1, 8'h1f, 256'd0,   NEG, "R8 ror by 0");
    step(1, 8'h00, 256'd3,   NEG, "R1 illegal 0x00");
    step(1, 8'h1a, 256'd3,   NEG, "R1 illegal 0x1a");
    step(1, 8'h20, 256'd3,   NEG, "R1 illegal 0x20");
    step(1, 8'hff, 256'd3,   NEG, "R1 illegal 0xff");
    step(0, 8'h1b, 256'd1,   POS, "R9 idle holds");
    step(0, 8'h1c, 256'd9,   NEG, "R9 idle holds again");
    step(1, 8'h1e, 256'd13,  NEG, "R9 resume");

    for (int n = 0; n < 1500; n++) begin
      logic [255:0] a;
      logic [7:0] op;
      op = 8'h1b + 8'($urandom_range(0, 4));
      a = rnd256();
      case ($urandom_range(0, 2))
        0: a = {248'd0, a[7:0]};
        1: a = {a[255:8] & {248{($urandom_range(0, 1) == 1)}}, a[7:0]};
        default: ;
      endcase
      step(($urandom_range(0, 5) != 0), op, a, rnd256(), "R1 random mix");
    end

    rst = 1'b1;
    step(1, 8'h1b, 256'd1, POS, "R10 reset in run");
    rst = 1'b0;
    step(1, 8'h1d, 256'd8, NEG, "R5 after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule